// File: doc/BRIEF.md
# Three-Digit Decimal Event Counter

This block counts events in decimal, from 000 up to 999 and then back to 000. It is built from three identical four-bit BCD stages: a ones stage, a tens stage and a hundreds stage. A single system clock drives every flip-flop. A one-cycle strobe, `cnt_pulse`, takes the place of a ripple clock and marks each event to be counted.

Within a stage, each bit is a JK-style toggle cell with its own strobe. The lowest bit is strobed by the incoming event. The second and fourth bits are strobed by the falling edge of the lowest bit. The third bit is strobed by the falling edge of the second bit. A stage passes an event to the stage above it only when its own most significant bit falls from 1 to 0. No value compare is used for this carry. The falling edges are found in the same clock cycle from the current bit values and the strobes, so the whole chain settles on one clock edge.

A synchronous clear takes priority over counting. The `term_cnt` output goes high when the count stands at 999 and an event arrives, so a further counter can be chained after this one.

Top module: `decade_event_counter`

## Requirements
- R1: Each digit output always holds a BCD value from 0 to 9 (binary 4'b0000 to 4'b1001), starting from the first clock after a clear.
- R2: When `sclr` is high at a rising edge, all three digits are 0 after that edge, whether or not `cnt_pulse` is high.
- R3: When neither `sclr` nor `cnt_pulse` is high at a rising edge, all three digits keep their values.
- R4: With `cnt_pulse` high and `sclr` low, the ones digit goes up by one at the edge, and from 9 it goes to 0.
- R5: The tens digit changes only on a pulse that wraps the ones digit from 9 to 0, and it then goes up by one (9 goes to 0). The hundreds digit follows the same rule with respect to the tens digit.
- R6: A pulse while the count is 999 gives 000 after the edge.
- R7: `term_cnt` is high in a cycle exactly when `cnt_pulse` is high and the digits read 9, 9, 9. It is a combinational output and is not registered.
- R8: Inside a stage, the step from 7 to 8 sets the most significant bit and clears the three lower bits on the same edge. The step from 9 to 0 clears the most significant bit and sends an event to the next stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| sclr | input | 1 | Synchronous clear; takes priority over counting |
| cnt_pulse | input | 1 | Count event strobe, one count per cycle it is high |
| digit_ones | output | 4 | Ones digit, BCD |
| digit_tens | output | 4 | Tens digit, BCD |
| digit_hund | output | 4 | Hundreds digit, BCD |
| term_cnt | output | 1 | High when the count is 999 and `cnt_pulse` is high |

## Verification
The assertions assume that `sclr` is high at least once before the counter is in use. Their checks stay disabled until the first clear, because the flip-flops hold no defined value before it. They also assume that `cnt_pulse` and `sclr` are stable around the rising edge. The stimulus meets both assumptions. It raises `sclr` in the first cycles and changes every input on the falling edge. Clears are drawn only rarely, so that long runs of counting carry the count through 999 and back to 000.

// File: rtl/decade_cnt_pkg.sv
package decade_cnt_pkg;
   localparam int unsigned DIGIT_W  = 4;
   localparam int unsigned DIGIT_MAX = 9;
   typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/jk_toggle_cell.sv
module jk_toggle_cell (
   input  logic clk,
   input  logic sclr,
   input  logic strobe,
   input  logic j_in,
   input  logic k_in,
   output logic q,
   output logic falls
);
   logic q_next;

   always_comb begin
      q_next = q;
      if (strobe) begin
         unique case ({j_in, k_in})
            2'b10:   q_next = 1'b1;
            2'b01:   q_next = 1'b0;
            2'b11:   q_next = ~q;
            default: q_next = q;
         endcase
      end
   end

   assign falls = q & ~q_next;

   always_ff @(posedge clk) begin
      if (sclr) q <= 1'b0;
      else      q <= q_next;
   end
endmodule

// File: rtl/bcd_jk_decade.sv
module bcd_jk_decade
   import decade_cnt_pkg::*;
(
   input  logic       clk,
   input  logic       sclr,
   input  logic       evt_in,
   output bcd_digit_t digit,
   output logic       evt_out
);
   logic [DIGIT_W-1:0] q;
   logic [DIGIT_W-1:0] fall;
   logic [DIGIT_W-1:0] stb;
   logic [DIGIT_W-1:0] jv;
   logic [DIGIT_W-1:0] kv;

   always_comb begin
      stb[0] = evt_in;  jv[0] = 1'b1;          kv[0] = 1'b1;
      stb[1] = fall[0]; jv[1] = ~q[3];         kv[1] = 1'b1;
      stb[2] = fall[1]; jv[2] = 1'b1;          kv[2] = 1'b1;
      stb[3] = fall[0]; jv[3] = q[1] & q[2];   kv[3] = 1'b1;
   end

   for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
      jk_toggle_cell u_cell (
         .clk    (clk),
         .sclr   (sclr),
         .strobe (stb[b]),
         .j_in   (jv[b]),
         .k_in   (kv[b]),
         .q      (q[b]),
         .falls  (fall[b])
      );
   end

   assign digit   = q;
   assign evt_out = fall[3];
endmodule

// File: rtl/decade_chain.sv
module decade_chain
   import decade_cnt_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3
) (
   input  logic                                clk,
   input  logic                                sclr,
   input  logic                                evt_in,
   output logic [NUM_DECADES-1:0][DIGIT_W-1:0] digits,
   output logic                                carry_out
);
   logic [NUM_DECADES:0] link;

   if (NUM_DECADES < 1) begin : g_bad_depth
      $error("decade_chain: NUM_DECADES must be at least 1");
   end

   assign link[0] = evt_in;

   for (genvar d = 0; d < NUM_DECADES; d++) begin : g_dec
      bcd_jk_decade u_dec (
         .clk     (clk),
         .sclr    (sclr),
         .evt_in  (link[d]),
         .digit   (digits[d]),
         .evt_out (link[d+1])
      );
   end

   assign carry_out = link[NUM_DECADES];
endmodule

// File: rtl/decade_event_counter.sv
module decade_event_counter
   import decade_cnt_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3
) (
   input  logic       clk,
   input  logic       sclr,
   input  logic       cnt_pulse,
   output logic [3:0] digit_ones,
   output logic [3:0] digit_tens,
   output logic [3:0] digit_hund,
   output logic       term_cnt
);
   if (NUM_DECADES != 3) begin : g_bad_cfg
      $error("decade_event_counter: port list carries exactly three digits");
   end
   if (DIGIT_W != 4) begin : g_bad_width
      $error("decade_event_counter: BCD digits must be four bits wide");
   end

   logic [NUM_DECADES-1:0][DIGIT_W-1:0] dig;

   decade_chain #(.NUM_DECADES(NUM_DECADES)) u_chain (
      .clk       (clk),
      .sclr      (sclr),
      .evt_in    (cnt_pulse),
      .digits    (dig),
      .carry_out (term_cnt)
   );

   assign digit_ones = dig[0];
   assign digit_tens = dig[1];
   assign digit_hund = dig[2];
endmodule

// File: rtl/decade_event_counter_chk.sv
module decade_event_counter_chk (
   input logic       clk,
   input logic       sclr,
   input logic       cnt_pulse,
   input logic [3:0] digit_ones,
   input logic [3:0] digit_tens,
   input logic [3:0] digit_hund,
   input logic       term_cnt
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (sclr) armed <= 1'b1;

   p_digit_range_r1: assert property (@(posedge clk) disable iff (!armed)
      (digit_ones <= 4'd9) && (digit_tens <= 4'd9) && (digit_hund <= 4'd9));

   p_clear_zero_r2: assert property (@(posedge clk) disable iff (!armed)
      sclr |=> (digit_ones == 4'd0) && (digit_tens == 4'd0) && (digit_hund == 4'd0));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!armed)
      (!sclr && !cnt_pulse) |=> $stable(digit_ones) && $stable(digit_tens) && $stable(digit_hund));

   p_ones_step_r4: assert property (@(posedge clk) disable iff (!armed)
      (!sclr && cnt_pulse && digit_ones != 4'd9) |=>
         (digit_ones == $past(digit_ones) + 4'd1) && $stable(digit_tens) && $stable(digit_hund));

   p_tens_step_r5: assert property (@(posedge clk) disable iff (!armed)
      (!sclr && cnt_pulse && digit_ones == 4'd9 && digit_tens != 4'd9) |=>
         (digit_ones == 4'd0) && (digit_tens == $past(digit_tens) + 4'd1) && $stable(digit_hund));

   p_wrap_all_r6: assert property (@(posedge clk) disable iff (!armed)
      (!sclr && term_cnt) |=> (digit_ones == 4'd0) && (digit_tens == 4'd0) && (digit_hund == 4'd0));

   p_tc_needs_pulse_r7: assert property (@(posedge clk) disable iff (!armed)
      term_cnt |-> cnt_pulse && digit_hund == 4'd9);

   p_msb_set_r8: assert property (@(posedge clk) disable iff (!armed)
      (!sclr && cnt_pulse && digit_ones == 4'd7) |=> digit_ones == 4'b1000);
endmodule

bind decade_event_counter decade_event_counter_chk u_chk (
   .clk        (clk),
   .sclr       (sclr),
   .cnt_pulse  (cnt_pulse),
   .digit_ones (digit_ones),
   .digit_tens (digit_tens),
   .digit_hund (digit_hund),
   .term_cnt   (term_cnt)
);

// File: tb/decade_event_counter_bench.sv
module decade_event_counter_bench;
   logic       clk = 1'b0;
   logic       sclr = 1'b0;
   logic       cnt_pulse = 1'b0;
   logic [3:0] digit_ones, digit_tens, digit_hund;
   logic       term_cnt;

   int checks = 0;
   int errors = 0;
   int ref_val = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   decade_event_counter u_decade_event_counter (
      .clk(clk), .sclr(sclr), .cnt_pulse(cnt_pulse),
      .digit_ones(digit_ones), .digit_tens(digit_tens),
      .digit_hund(digit_hund), .term_cnt(term_cnt));

   function automatic int dut_value();
      return digit_hund * 100 + digit_tens * 10 + digit_ones;
   endfunction

   function automatic int next_ref(int cur, bit clr, bit pul);
      if (clr) return 0;
      if (pul) return (cur + 1) % 1000;
      return cur;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // compare digits with reference, and term_cnt after inputs are set
   task automatic step(bit clr, bit pul, string req);
      @(negedge clk);
      chk(digit_ones == 4'(ref_val % 10) && digit_tens == 4'((ref_val / 10) % 10)
          && digit_hund == 4'(ref_val / 100), req, dut_value(), ref_val);
      chk(digit_ones <= 4'd9 && digit_tens <= 4'd9 && digit_hund <= 4'd9, "R1",
          dut_value(), ref_val);
      sclr = clr;
      cnt_pulse = pul;
      #1;
      chk(term_cnt == (pul && ref_val == 999), "R7", int'(term_cnt),
          int'(pul && ref_val == 999));
      if (pul && !clr) pulses++;
      ref_val = next_ref(ref_val, clr, pul);
   endtask

   initial begin
      void'($urandom(32'd20240711));
      // reset state via clear
      sclr = 1'b1;
      @(negedge clk); @(negedge clk);
      step(1'b1, 1'b1, "R2");      // clear beats pulse
      step(1'b0, 1'b0, "R2");
      // directed: count through 7->8 and 9->0 with idle gaps
      for (int i = 0; i < 12; i++) begin
         step(1'b0, 1'b1, (ref_val % 10 == 7) ? "R8" : "R4");
         step(1'b0, 1'b0, "R3");
      end
      // directed: straight run to 999, then wrap
      while (ref_val != 999) step(1'b0, 1'b1, "R5");
      step(1'b0, 1'b0, "R3");
      step(1'b0, 1'b1, "R7");
      step(1'b0, 1'b0, "R6");
      // clear while at 999 with pulse
      while (ref_val != 999) step(1'b0, 1'b1, "R5");
      step(1'b1, 1'b1, "R2");
      step(1'b0, 1'b0, "R2");
      // constrained random
      for (int i = 0; i < 2500; i++) begin
         bit c, p;
         c = ($urandom % 600) == 0;
         p = ($urandom % 4) != 0;
         step(c, p, "R5");
      end
      step(1'b0, 1'b0, "R3");
      chk(pulses >= 1200, "R6", pulses, 1200);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule